// File: doc/BRIEF.md
# Byte-Wide Host to Word-Wide DSP Bridge

This bridge sits between an 8-bit host bus and a signal-processing core that works on 16-bit data words and 24-bit instruction words. The host writes up to three byte registers one at a time. The core then sees them as one wide inbound word. In the other direction, the core deposits a 16-bit result, and the host fetches it as a low byte and a high byte. A host-readable status byte combines the two handshake flags with six flag bits that core software sets. Each direction has a full flag, so neither side can overwrite data that has not been read, and neither side can pick up data that is not valid.

The host must write the bytes of an inbound word from the least significant to the most significant. A word becomes visible only when its top byte is written. Address 2 closes a 24-bit word. Address 6 closes a 16-bit word and clears the upper byte. For program download, the core raises a boot request. The bridge then stalls the core until a full inbound word is present. In the next cycle it writes that word into program memory at an internal pointer, advances the pointer, and frees the inbound register for the next word.

Top module: `hostword_bridge`

## Requirements
- R1: After reset, both full flags, the status byte, the software flags and the program pointer are all zero.
- R2: Host writes to address 0 (bits 7:0), address 1 (bits 15:8) and address 2 (bits 23:16) build the inbound word. Writing address 2 sets `d_in_ready` on the next clock edge. Writing address 0 or 1 alone does not set it.
- R3: A host write to address 6 stores bits 15:8, clears bits 23:16 and sets `d_in_ready`. This closes a 16-bit word.
- R4: While `d_in_ready` is set, host writes to addresses 0, 1, 2 and 6 are ignored. A `d_in_rd` pulse clears `d_in_ready` on the next edge.
- R5: `d_in_word` reads as zero while `d_in_ready` is clear, and a `d_in_rd` pulse in that state has no effect.
- R6: `d_out_wr` loads `d_out_word` and sets `d_out_busy`. A host read of address 3 returns bits 7:0 and leaves the flag set. A host read of address 4 returns bits 15:8 and clears the flag.
- R7: `d_out_wr` while `d_out_busy` is set is ignored. Addresses 3 and 4 read as zero while the flag is clear.
- R8: Address 5 reads as the status byte: bit 7 is the inbound full flag, bit 6 is the outbound full flag, and bits 5:0 are the software flags loaded by `d_flag_wr`.
- R9: While `boot_req` is high and no inbound word is present, `core_stall` is high and `pm_we` is low. Once a word is present, `pm_we` pulses for one cycle with `pm_addr` equal to the pointer and `pm_wdata` equal to the word. The pulse clears the inbound full flag.
- R10: Each program write advances the pointer by one, wrapping from its maximum to zero. `boot_ptr_ld` loads the pointer from `boot_ptr_val`.
- R11: Address 7 reads as zero. Host writes to addresses 3, 4, 5 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_addr | input | 3 | Host register select |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte for `h_addr` |
| d_in_rd | input | 1 | Core consumes the inbound word |
| d_in_word | output | 24 | Assembled inbound word |
| d_in_ready | output | 1 | Inbound full flag |
| d_out_wr | input | 1 | Core writes an outbound word |
| d_out_word | input | 16 | Outbound word from the core |
| d_out_busy | output | 1 | Outbound full flag |
| d_flag_wr | input | 1 | Load the software flags |
| d_flags | input | 6 | Software flag values |
| boot_req | input | 1 | Core is executing the wait-and-load instruction |
| boot_ptr_ld | input | 1 | Load the program pointer |
| boot_ptr_val | input | 10 | New program pointer value |
| core_stall | output | 1 | Hold the core |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | 10 | Program memory address (the pointer) |
| pm_wdata | output | 24 | Program memory write data |

## Verification
The hardest case to reach is the pointer wrap during a program download. It needs many download words from reset, and each one is a full three-write host transaction completed under a held boot request. The bench reaches it in a few cycles by loading the pointer to its maximum through `boot_ptr_ld`. It then streams two words with `boot_req` high and checks that the second write lands at address zero. The same sequence confirms the stall both before and after each write.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int HB_W = 8;

  localparam logic [2:0] SEL_IN0   = 3'd0;
  localparam logic [2:0] SEL_IN1   = 3'd1;
  localparam logic [2:0] SEL_IN2   = 3'd2;
  localparam logic [2:0] SEL_OUTLO = 3'd3;
  localparam logic [2:0] SEL_OUTHI = 3'd4;
  localparam logic [2:0] SEL_STAT  = 3'd5;
  localparam logic [2:0] SEL_IN1C  = 3'd6;

  // True for host addresses that feed the inbound word
  function automatic logic is_in_sel(input logic [2:0] sel);
    return (sel == SEL_IN0) || (sel == SEL_IN1) || (sel == SEL_IN2) || (sel == SEL_IN1C);
  endfunction

  // Status byte: inbound full, outbound full, software flags
  function automatic logic [HB_W-1:0] pack_status(input logic in_full, input logic out_full,
                                                  input logic [HB_W-3:0] sw);
    return {in_full, out_full, sw};
  endfunction

  // Host read multiplexer
  function automatic logic [HB_W-1:0] host_read(input logic [2:0] sel, input logic [HB_W-1:0] lo,
                                                input logic [HB_W-1:0] hi, input logic [HB_W-1:0] st);
    case (sel)
      SEL_OUTLO: return lo;
      SEL_OUTHI: return hi;
      SEL_STAT:  return st;
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/hb_inbox.sv
module hb_inbox import hb_pkg::*; #(
  parameter int IW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [7:0]    wr_byte,
  input  logic          consume,
  output logic          full,
  output logic          commit_evt,
  output logic [IW-1:0] word
);
  localparam int NB = IW / HB_W;
  localparam int SHORT_TOP = DW / HB_W - 1;

  logic [HB_W-1:0] byte_q [NB];
  logic            accept;
  logic [IW-1:0]   joined;

  assign accept     = wr_en && !full;
  assign commit_evt = accept && (wr_sel == 3'(NB-1) || wr_sel == SEL_IN1C);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q[i] <= '0;
      else if (accept) begin
        if (wr_sel == 3'(i) || (wr_sel == SEL_IN1C && i == SHORT_TOP)) byte_q[i] <= wr_byte;
        else if (wr_sel == SEL_IN1C && i > SHORT_TOP) byte_q[i] <= '0;
      end
    end
  end

  always_comb begin
    joined = '0;
    for (int k = 0; k < NB; k++) joined[k*HB_W +: HB_W] = byte_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else if (commit_evt) full <= 1'b1;
    else if (consume) full <= 1'b0;
  end

  assign word = full ? joined : '0;

  a_r4_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    full && !consume |=> full && $stable(word));
  a_r2_set_by_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(commit_evt));
endmodule

// File: rtl/hb_outbox.sv
module hb_outbox import hb_pkg::*; #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            d_wr,
  input  logic [DW-1:0]   d_word,
  input  logic            rd_lo,
  input  logic            rd_hi,
  output logic            full,
  output logic [HB_W-1:0] lo_byte,
  output logic [HB_W-1:0] hi_byte
);
  logic [DW-1:0] word_q;
  logic          load, drain;

  assign load  = d_wr && !full;
  assign drain = rd_hi && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      full   <= 1'b0;
    end else if (load) begin
      word_q <= d_word;
      full   <= 1'b1;
    end else if (drain) begin
      full   <= 1'b0;
    end
  end

  assign lo_byte = full ? word_q[HB_W-1:0] : '0;
  assign hi_byte = full ? word_q[DW-1:HB_W] : '0;

  a_r6_low_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    full && rd_lo && !rd_hi |=> full);
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    full && !drain |=> full && $stable(word_q));
endmodule

// File: rtl/hb_bootld.sv
module hb_bootld #(
  parameter int IW = 24,
  parameter int PA = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_req,
  input  logic          in_full,
  input  logic [IW-1:0] in_word,
  input  logic          ptr_ld,
  input  logic [PA-1:0] ptr_val,
  output logic          stall,
  output logic          take,
  output logic          pm_we,
  output logic [PA-1:0] pm_addr,
  output logic [IW-1:0] pm_wdata
);
  logic [PA-1:0] ptr_q;

  assign take     = boot_req && in_full;
  assign stall    = boot_req && !in_full;
  assign pm_we    = take;
  assign pm_addr  = ptr_q;
  assign pm_wdata = in_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (ptr_ld) ptr_q <= ptr_val;
    else if (take) ptr_q <= ptr_q + 1'b1;
  end

  a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we && !ptr_ld |=> ptr_q == $past(ptr_q) + 1'b1);
  a_r9_stall_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !pm_we);
endmodule

// File: rtl/hostword_bridge.sv
module hostword_bridge import hb_pkg::*; #(
  parameter int IW = 24,
  parameter int DW = 16,
  parameter int PA = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            h_wr,
  input  logic            h_rd,
  input  logic [2:0]      h_addr,
  input  logic [HB_W-1:0] h_wdata,
  output logic [HB_W-1:0] h_rdata,
  input  logic            d_in_rd,
  output logic [IW-1:0]   d_in_word,
  output logic            d_in_ready,
  input  logic            d_out_wr,
  input  logic [DW-1:0]   d_out_word,
  output logic            d_out_busy,
  input  logic            d_flag_wr,
  input  logic [HB_W-3:0] d_flags,
  input  logic            boot_req,
  input  logic            boot_ptr_ld,
  input  logic [PA-1:0]   boot_ptr_val,
  output logic            core_stall,
  output logic            pm_we,
  output logic [PA-1:0]   pm_addr,
  output logic [IW-1:0]   pm_wdata
);
  logic            in_wr_en, in_consume, in_commit, boot_take;
  logic            rd_lo_evt, rd_hi_evt;
  logic [HB_W-1:0] out_lo, out_hi, status;
  logic [HB_W-3:0] sw_q;

  assign in_wr_en   = h_wr && is_in_sel(h_addr);
  assign rd_lo_evt  = h_rd && h_addr == SEL_OUTLO;
  assign rd_hi_evt  = h_rd && h_addr == SEL_OUTHI;
  assign in_consume = boot_take || (d_in_rd && !boot_req && d_in_ready);

  hb_inbox #(.IW(IW), .DW(DW)) u_in (
    .clk(clk), .rst_n(rst_n), .wr_en(in_wr_en), .wr_sel(h_addr), .wr_byte(h_wdata),
    .consume(in_consume), .full(d_in_ready), .commit_evt(in_commit), .word(d_in_word));

  hb_outbox #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .d_wr(d_out_wr), .d_word(d_out_word), .rd_lo(rd_lo_evt),
    .rd_hi(rd_hi_evt), .full(d_out_busy), .lo_byte(out_lo), .hi_byte(out_hi));

  hb_bootld #(.IW(IW), .PA(PA)) u_boot (
    .clk(clk), .rst_n(rst_n), .boot_req(boot_req), .in_full(d_in_ready), .in_word(d_in_word),
    .ptr_ld(boot_ptr_ld), .ptr_val(boot_ptr_val), .stall(core_stall), .take(boot_take),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else if (d_flag_wr) sw_q <= d_flags;
  end

  assign status  = pack_status(d_in_ready, d_out_busy, sw_q);
  assign h_rdata = host_read(h_addr, out_lo, out_hi, status);

  a_r9_write_frees: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |=> !d_in_ready);
  a_r2_commit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    in_commit |=> d_in_ready);
endmodule

// File: tb/sim_hostword_bridge.sv
`timescale 1ns/1ps
module sim_hostword_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_wr = 0, h_rd = 0, d_in_rd = 0, d_out_wr = 0, d_flag_wr = 0;
  logic boot_req = 0, boot_ptr_ld = 0;
  logic [2:0] h_addr = 0;
  logic [7:0] h_wdata = 0, h_rdata;
  logic [23:0] d_in_word, pm_wdata;
  logic d_in_ready, d_out_busy, core_stall, pm_we;
  logic [15:0] d_out_word = 0;
  logic [5:0] d_flags = 0;
  logic [9:0] boot_ptr_val = 0, pm_addr;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  hostword_bridge u0 (.*);

  localparam logic [3:0] OP_HW = 0, OP_HR = 1, OP_DR = 2, OP_DW = 3, OP_FL = 4, OP_RDY = 5;
  // {op, addr, data, expected}
  localparam logic [55:0] VEC [24] = '{
    {OP_HW, 4'd0, 24'h11, 24'h0}, {OP_HW, 4'd1, 24'h22, 24'h0},
    {OP_RDY, 4'd0, 24'h0, 24'h0},                               // R2 not yet full
    {OP_HW, 4'd2, 24'h33, 24'h0},
    {OP_HR, 4'd5, 24'h0, 24'h80},                               // R8 in full bit
    {OP_HW, 4'd0, 24'h99, 24'h0},                               // R4 ignored
    {OP_DR, 4'd0, 24'h0, 24'h332211},                           // R2/R4
    {OP_RDY, 4'd0, 24'h0, 24'h0},
    {OP_DR, 4'd0, 24'h0, 24'h0},                                // R5
    {OP_HW, 4'd0, 24'h44, 24'h0}, {OP_HW, 4'd6, 24'h55, 24'h0},
    {OP_DR, 4'd0, 24'h0, 24'h005544},                           // R3
    {OP_DW, 4'd0, 24'hBEEF, 24'h0},
    {OP_HR, 4'd3, 24'h0, 24'hEF},                               // R6
    {OP_HR, 4'd5, 24'h0, 24'h40},                               // R6 still busy
    {OP_DW, 4'd0, 24'h1234, 24'h0},                             // R7 ignored
    {OP_HR, 4'd4, 24'h0, 24'hBE},                               // R6/R7
    {OP_HR, 4'd3, 24'h0, 24'h00},                               // R7
    {OP_HR, 4'd5, 24'h0, 24'h00},
    {OP_FL, 4'd0, 24'h2A, 24'h0},
    {OP_HR, 4'd5, 24'h0, 24'h2A},                               // R8
    {OP_HR, 4'd7, 24'h0, 24'h00},                               // R11
    {OP_HW, 4'd5, 24'hFF, 24'h0},
    {OP_HR, 4'd5, 24'h0, 24'h2A}                                // R11 write ignored
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    h_wr = 0; h_rd = 0; d_in_rd = 0; d_out_wr = 0; d_flag_wr = 0; boot_ptr_ld = 0;
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); idle(); h_wr = 1; h_addr = a; h_wdata = d;
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); h_addr = 3'd5; #1;
    chk(h_rdata == 8'h00, "R1 status", h_rdata, 0);
    chk(!d_in_ready && !d_out_busy && !core_stall && !pm_we && pm_addr == 0, "R1 flags", pm_addr, 0);

    for (int i = 0; i < 24; i++) begin
      logic [3:0] op; logic [2:0] a; logic [23:0] d, e;
      {op, a, d, e} = {VEC[i][55:52], VEC[i][50:48], VEC[i][47:24], VEC[i][23:0]};
      @(negedge clk); idle(); h_addr = a;
      case (op)
        OP_HW: begin h_wr = 1; h_wdata = d[7:0]; end
        OP_HR: h_rd = 1;
        OP_DR: d_in_rd = 1;
        OP_DW: begin d_out_wr = 1; d_out_word = d[15:0]; end
        OP_FL: begin d_flag_wr = 1; d_flags = d[5:0]; end
        default: ;
      endcase
      #1;
      case (op)
        OP_HR:  chk(h_rdata == e[7:0], $sformatf("R6-8 vec %0d", i), h_rdata, e);
        OP_DR:  chk(d_in_word == e, $sformatf("R2 R3 R5 vec %0d", i), d_in_word, e);
        OP_RDY: chk(d_in_ready == e[0], $sformatf("R4 vec %0d", i), d_in_ready, e);
        default: ;
      endcase
    end

    // R10 pointer load to top, R9 boot download
    @(negedge clk); idle(); boot_ptr_ld = 1; boot_ptr_val = 10'h3FF;
    @(negedge clk); idle(); boot_req = 1; #1;
    chk(core_stall && !pm_we, "R9 stall empty", core_stall, 1);
    chk(pm_addr == 10'h3FF, "R10 load", pm_addr, 10'h3FF);
    hwrite(0, 8'hA1); hwrite(1, 8'hB2); hwrite(2, 8'hC3);
    @(negedge clk); idle(); #1;
    chk(pm_we && !core_stall, "R9 write pulse", pm_we, 1);
    chk(pm_wdata == 24'hC3B2A1, "R9 data", pm_wdata, 24'hC3B2A1);
    chk(pm_addr == 10'h3FF, "R9 addr", pm_addr, 10'h3FF);
    @(negedge clk); #1;
    chk(!d_in_ready && core_stall && !pm_we, "R9 freed", d_in_ready, 0);
    chk(pm_addr == 10'h000, "R10 wrap", pm_addr, 0);
    hwrite(0, 8'h01); hwrite(6, 8'h02);
    @(negedge clk); idle(); #1;
    chk(pm_we && pm_wdata == 24'h000201 && pm_addr == 0, "R9 second word", pm_wdata, 24'h000201);
    @(negedge clk); #1;
    chk(pm_addr == 10'h001, "R10 step", pm_addr, 1);
    boot_req = 0;

    // R1 reset mid-run
    @(negedge clk); d_out_wr = 1; d_out_word = 16'h5A5A; d_flag_wr = 1; d_flags = 6'h3F;
    @(negedge clk); idle(); rst_n = 0; #1;
    h_addr = 3'd5; #1;
    chk(h_rdata == 8'h00 && pm_addr == 0, "R1 reset again", h_rdata, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule